// File: doc/BRIEF.md
# DMA Controller Register Interface

This block is the programming side of a four-channel DMA controller. A host reaches it over a byte-wide register bus with a 4-bit register index. Indices 0 to 7 select a channel's base address or base count. Indices 8 to 15 select the controller-wide controls: command, software request, single-mask, mode, byte-pointer clear, master reset, clear-all-mask and load-all-mask. Status and mask can also be read back.

The 16-bit channel registers are reached one byte at a time through a single byte pointer that all channels share. Each channel access toggles it, and the low byte comes first. Writing the high byte of either base register starts the channel afresh: the current address is loaded from the base address and the transferred count goes to zero.

A transfer engine sits beside the block and uses its outputs: per-channel mode, mask, request, current address, transferred count and programmed length, plus a controller-off flag. The engine reports progress back through an advance pulse and a terminal-count pulse per channel. Reads return data one cycle after the request.

Top module: `dmac_regs`

## Requirements
- R1: After reset all mask bits are 1, and status, controller-off, byte pointer, read data and every channel register (base, current address, transferred count, mode) are 0.
- R2: For indices 0 to 7, bits [2:1] pick the channel and bit 0 picks the register (0 address, 1 count). Every read or write at these indices toggles the shared byte pointer. Pointer 0 reaches bits [7:0] and pointer 1 reaches bits [15:8].
- R3: A high-byte write to either base register of a channel loads that channel's current address from its base address, including the byte just written, and clears its transferred count to 0.
- R4: A write to index 8 sets controller-off to data bit 2 when the data is 0x00 or 0x04. Any other value is ignored.
- R5: A write to index 9 sets or clears request bit (4 + data[1:0]) of status according to data[2], and clears status bit data[1:0].
- R6: Index 10 sets mask bit data[1:0] to data[2]. Index 14 clears all mask bits. Index 15 loads the mask from data[3:0].
- R7: Index 11 stores the whole data byte as the mode of channel data[1:0]. Mode bit 5 selects address decrement.
- R8: Index 12 clears the byte pointer. Index 13 clears the byte pointer, status and controller-off and sets all mask bits. It leaves modes and channel registers unchanged.
- R9: Reading index 8 returns status {request[3:0], terminal-count[3:0]} and then clears the terminal-count nibble. Reading index 15 returns {4'b0, mask}. Reads of indices 9 to 14 return 0.
- R10: A count read returns base count minus transferred count. An address read returns current address plus transferred count, or current address minus transferred count when mode bit 5 is set. Both wrap at 16 bits.
- R11: An advance pulse adds 1 to that channel's transferred count. A terminal-count pulse sets status bit (channel). The pulse wins over a clear made in the same cycle. A high-byte reload wins over an advance.
- R12: Read data appears on bus_rdata in the cycle after bus_rd and holds until the next read. When bus_rd and bus_wr are both high, the write is done and the read is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_idx | input | 4 | Register index |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| xfer_adv | input | 4 | Per-channel advance pulse from the transfer engine |
| xfer_tc | input | 4 | Per-channel terminal-count pulse |
| ch_mode | output | 32 | Mode byte of each channel, channel c at [8c+7:8c] |
| ch_mask | output | 4 | Mask bit of each channel |
| ch_req | output | 4 | Software request bit of each channel |
| ch_addr | output | 64 | Current address of each channel |
| ch_done | output | 64 | Transferred count of each channel |
| ch_len | output | 64 | Programmed base count of each channel |
| ctl_off | output | 1 | Controller-off flag from the command register |

## Verification
The hardest cases to reach from the ports depend on the byte pointer's phase, which no output shows. A high-byte reload or a readback of the upper byte only happens after an odd number of earlier channel accesses, and these may have gone to other channels. The stimulus therefore mixes random channel reads and writes with pointer clears, master resets and engine advance pulses. A bench model follows the pointer phase on its own, so every readback is checked at whatever phase the random history leaves. Directed sequences add decrement-mode address readback after advances, rejected command values, and a terminal-count flag that is cleared by a status read.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
   localparam int NCH   = 4;
   localparam int CH_W  = 2;
   localparam int DEC_BIT = 5;
   localparam logic [7:0] CMD_ACCEPT = 8'h04;

   typedef enum logic [2:0] {
      OP_CMD   = 3'd0,
      OP_REQ   = 3'd1,
      OP_MSK1  = 3'd2,
      OP_MODE  = 3'd3,
      OP_PCLR  = 3'd4,
      OP_MRST  = 3'd5,
      OP_MCLR  = 3'd6,
      OP_MALL  = 3'd7
   } ctl_op_e;
endpackage

// File: rtl/dmac_chan.sv
module dmac_chan #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic         reg_cnt,
   input  logic         hi,
   input  logic [7:0]   wdata,
   input  logic         mode_we,
   input  logic         adv,
   output logic [W-1:0] base_cnt,
   output logic [W-1:0] cur_addr,
   output logic [W-1:0] done_cnt,
   output logic [7:0]   mode,
   output logic [W-1:0] rb_addr,
   output logic [W-1:0] rb_cnt
);
   import dmac_pkg::*;

   logic [W-1:0] base_addr, base_a_nx, base_c_nx, byte_merge_a, byte_merge_c;
   logic         reload;

   // byte merge for an incoming write, high byte trimmed to the width
   always_comb begin
      byte_merge_a = hi ? {wdata[W-9:0], base_addr[7:0]} : {base_addr[W-1:8], wdata};
      byte_merge_c = hi ? {wdata[W-9:0], base_cnt[7:0]}  : {base_cnt[W-1:8], wdata};
      base_a_nx = (we && !reg_cnt) ? byte_merge_a : base_addr;
      base_c_nx = (we &&  reg_cnt) ? byte_merge_c : base_cnt;
   end

   assign reload = we && hi;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_addr <= '0;
         base_cnt  <= '0;
         cur_addr  <= '0;
         done_cnt  <= '0;
         mode      <= '0;
      end else begin
         base_addr <= base_a_nx;
         base_cnt  <= base_c_nx;
         if (reload) begin
            cur_addr <= base_a_nx;
            done_cnt <= '0;
         end else if (adv) begin
            done_cnt <= done_cnt + 1'b1;
         end
         if (mode_we) mode <= wdata;
      end
   end

   assign rb_addr = mode[DEC_BIT] ? (cur_addr - done_cnt) : (cur_addr + done_cnt);
   assign rb_cnt  = base_cnt - done_cnt;
endmodule

// File: rtl/dmac_ctl.sv
module dmac_ctl (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr,
   input  logic       rd,
   input  logic [3:0] idx,
   input  logic [7:0] wdata,
   input  logic [3:0] tc_hit,
   output logic       ptr,
   output logic [3:0] mask,
   output logic [7:0] status,
   output logic       ctl_off,
   output logic [7:0] rd_ctl
);
   import dmac_pkg::*;

   logic       rd_eff, ch_acc, ctl_wr;
   ctl_op_e    op;
   logic       ptr_nx, off_nx;
   logic [3:0] mask_nx;
   logic [7:0] status_nx;
   logic [1:0] sel;

   assign rd_eff = rd && !wr;
   assign ch_acc = (wr || rd_eff) && !idx[3];
   assign ctl_wr = wr && idx[3];
   assign op     = ctl_op_e'(idx[2:0]);
   assign sel    = wdata[1:0];

   always_comb begin
      ptr_nx    = ch_acc ? ~ptr : ptr;
      mask_nx   = mask;
      status_nx = status;
      off_nx    = ctl_off;
      if (rd_eff && idx[3] && op == OP_CMD) status_nx[3:0] = 4'h0;
      if (ctl_wr) begin
         case (op)
            OP_CMD:  if ((wdata & ~CMD_ACCEPT) == 8'h00) off_nx = wdata[2];
            OP_REQ:  begin
                        status_nx[4 + sel] = wdata[2];
                        status_nx[sel]     = 1'b0;
                     end
            OP_MSK1: mask_nx[sel] = wdata[2];
            OP_MODE: ;
            OP_PCLR: ptr_nx = 1'b0;
            OP_MRST: begin
                        ptr_nx    = 1'b0;
                        mask_nx   = 4'hF;
                        status_nx = 8'h00;
                        off_nx    = 1'b0;
                     end
            OP_MCLR: mask_nx = 4'h0;
            OP_MALL: mask_nx = wdata[3:0];
            default: ;
         endcase
      end
      status_nx[3:0] = status_nx[3:0] | tc_hit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr     <= 1'b0;
         mask    <= 4'hF;
         status  <= 8'h00;
         ctl_off <= 1'b0;
      end else begin
         ptr     <= ptr_nx;
         mask    <= mask_nx;
         status  <= status_nx;
         ctl_off <= off_nx;
      end
   end

   always_comb begin
      case (op)
         OP_CMD:  rd_ctl = status;
         OP_MALL: rd_ctl = {4'h0, mask};
         default: rd_ctl = 8'h00;
      endcase
   end
endmodule

// File: rtl/dmac_regs.sv
module dmac_regs #(
   parameter int W = 16
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         bus_wr,
   input  logic                         bus_rd,
   input  logic [3:0]                   bus_idx,
   input  logic [7:0]                   bus_wdata,
   output logic [7:0]                   bus_rdata,
   input  logic [dmac_pkg::NCH-1:0]     xfer_adv,
   input  logic [dmac_pkg::NCH-1:0]     xfer_tc,
   output logic [dmac_pkg::NCH*8-1:0]   ch_mode,
   output logic [dmac_pkg::NCH-1:0]     ch_mask,
   output logic [dmac_pkg::NCH-1:0]     ch_req,
   output logic [dmac_pkg::NCH*W-1:0]   ch_addr,
   output logic [dmac_pkg::NCH*W-1:0]   ch_done,
   output logic [dmac_pkg::NCH*W-1:0]   ch_len,
   output logic                         ctl_off
);
   import dmac_pkg::*;

   if (W < 9 || W > 16) begin : g_bad_width
      $error("dmac_regs: W must lie in 9..16");
   end

   logic         ptr;
   logic [7:0]   status;
   logic [7:0]   rd_ctl;
   logic [W-1:0] rb_a [NCH];
   logic [W-1:0] rb_c [NCH];
   logic         ch_wr;
   logic         mode_wr;

   assign ch_wr   = bus_wr && !bus_idx[3];
   assign mode_wr = bus_wr && (bus_idx == {1'b1, OP_MODE});

   dmac_ctl u_ctl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (bus_wr),
      .rd      (bus_rd),
      .idx     (bus_idx),
      .wdata   (bus_wdata),
      .tc_hit  (xfer_tc),
      .ptr     (ptr),
      .mask    (ch_mask),
      .status  (status),
      .ctl_off (ctl_off),
      .rd_ctl  (rd_ctl)
   );

   assign ch_req = status[7:4];

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      dmac_chan #(.W(W)) u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .we       (ch_wr && (bus_idx[2:1] == CH_W'(c))),
         .reg_cnt  (bus_idx[0]),
         .hi       (ptr),
         .wdata    (bus_wdata),
         .mode_we  (mode_wr && (bus_wdata[1:0] == CH_W'(c))),
         .adv      (xfer_adv[c]),
         .base_cnt (ch_len[c*W +: W]),
         .cur_addr (ch_addr[c*W +: W]),
         .done_cnt (ch_done[c*W +: W]),
         .mode     (ch_mode[c*8 +: 8]),
         .rb_addr  (rb_a[c]),
         .rb_cnt   (rb_c[c])
      );
   end

   logic [15:0] rb_word;
   logic [7:0]  rd_val;

   always_comb begin
      rb_word = 16'(bus_idx[0] ? rb_c[bus_idx[2:1]] : rb_a[bus_idx[2:1]]);
      if (bus_idx[3]) rd_val = rd_ctl;
      else            rd_val = ptr ? rb_word[15:8] : rb_word[7:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 bus_rdata <= 8'h00;
      else if (bus_rd && !bus_wr) bus_rdata <= rd_val;
   end
endmodule

// File: rtl/dmac_regs_chk.sv
module dmac_regs_chk #(
   parameter int W = 16
) (
   input logic           clk,
   input logic           rst_n,
   input logic           bus_wr,
   input logic           bus_rd,
   input logic [3:0]     bus_idx,
   input logic [7:0]     bus_wdata,
   input logic [3:0]     xfer_tc,
   input logic           ptr,
   input logic [7:0]     status,
   input logic [3:0]     ch_mask,
   input logic           ctl_off,
   input logic [4*W-1:0] ch_done
);
   // R2
   ptr_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((bus_wr || bus_rd) && !bus_idx[3]) |=> (ptr != $past(ptr)));

   // R3
   reload_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !bus_idx[3] && ptr) |=> (ch_done[$past(bus_idx[2:1])*W +: W] == '0));

   // R4
   cmd_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_idx == 4'd8 && bus_wdata != 8'h00 && bus_wdata != 8'h04)
      |=> $stable(ctl_off));

   // R6
   mask_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_idx == 4'd14) |=> (ch_mask == 4'h0));

   // R8
   master_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_idx == 4'd13 && xfer_tc == 4'h0)
      |=> (ch_mask == 4'hF && status == 8'h00 && !ctl_off && !ptr));

   // R9
   status_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !bus_wr && bus_idx == 4'd8 && xfer_tc == 4'h0)
      |=> (status[3:0] == 4'h0));
endmodule

bind dmac_regs dmac_regs_chk #(.W(W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .bus_idx   (bus_idx),
   .bus_wdata (bus_wdata),
   .xfer_tc   (xfer_tc),
   .ptr       (ptr),
   .status    (status),
   .ch_mask   (ch_mask),
   .ctl_off   (ctl_off),
   .ch_done   (ch_done)
);

// File: tb/sim_dmac_regs.sv
`timescale 1ns/1ps
module sim_dmac_regs;
   localparam int W = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [3:0]  bus_idx = '0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic [3:0]  xfer_adv = '0, xfer_tc = '0;
   logic [31:0] ch_mode;
   logic [3:0]  ch_mask, ch_req;
   logic [63:0] ch_addr, ch_done, ch_len;
   logic        ctl_off;

   always #2.5 clk = ~clk;

   dmac_regs #(.W(W)) u0 (.*);

   int checks = 0, errors = 0;

   // bench reference state
   logic [15:0] m_ba [4], m_bc [4], m_cur [4], m_done [4];
   logic [7:0]  m_mode [4];
   logic [3:0]  m_mask, m_req, m_tc;
   logic        m_off, m_ptr;

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int c = 0; c < 4; c++) begin
         m_ba[c] = 0; m_bc[c] = 0; m_cur[c] = 0; m_done[c] = 0; m_mode[c] = 0;
      end
      m_mask = 4'hF; m_req = 0; m_tc = 0; m_off = 0; m_ptr = 0;
   endtask

   task automatic mwr(logic [3:0] idx, logic [7:0] d);
      int c;
      @(negedge clk);
      bus_wr = 1'b1; bus_idx = idx; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
      c = int'(idx[2:1]);
      if (!idx[3]) begin
         if (m_ptr) begin
            if (idx[0]) m_bc[c][15:8] = d; else m_ba[c][15:8] = d;
            m_cur[c] = m_ba[c]; m_done[c] = 0;
         end else begin
            if (idx[0]) m_bc[c][7:0] = d; else m_ba[c][7:0] = d;
         end
         m_ptr = ~m_ptr;
      end else case (idx)
         4'd8:  if (d == 8'h00 || d == 8'h04) m_off = d[2];
         4'd9:  begin m_req[d[1:0]] = d[2]; m_tc[d[1:0]] = 1'b0; end
         4'd10: m_mask[d[1:0]] = d[2];
         4'd11: m_mode[d[1:0]] = d;
         4'd12: m_ptr = 0;
         4'd13: begin m_ptr = 0; m_mask = 4'hF; m_req = 0; m_tc = 0; m_off = 0; end
         4'd14: m_mask = 0;
         default: m_mask = d[3:0];
      endcase
   endtask

   task automatic mrd(logic [3:0] idx, string tag);
      logic [15:0] v;
      logic [7:0]  e;
      int c;
      c = int'(idx[2:1]);
      if (!idx[3]) begin
         if (idx[0]) v = m_bc[c] - m_done[c];
         else v = m_mode[c][5] ? m_cur[c] - m_done[c] : m_cur[c] + m_done[c];
         e = m_ptr ? v[15:8] : v[7:0];
         m_ptr = ~m_ptr;
      end else if (idx == 4'd8) begin
         e = {m_req, m_tc}; m_tc = 0;
      end else if (idx == 4'd15) e = {4'h0, m_mask};
      else e = 8'h00;
      @(negedge clk);
      bus_rd = 1'b1; bus_idx = idx;
      @(negedge clk);
      bus_rd = 1'b0;
      chk(tag, 32'(bus_rdata), 32'(e));
   endtask

   task automatic pulse(logic [3:0] adv, logic [3:0] tc);
      @(negedge clk);
      xfer_adv = adv; xfer_tc = tc;
      @(negedge clk);
      xfer_adv = 0; xfer_tc = 0;
      for (int c = 0; c < 4; c++) if (adv[c]) m_done[c] = m_done[c] + 1;
      m_tc = m_tc | tc;
   endtask

   task automatic check_outs(string tag);
      chk({tag, " mask R6"}, 32'(ch_mask), 32'(m_mask));
      chk({tag, " req R5"}, 32'(ch_req), 32'(m_req));
      chk({tag, " off R4"}, 32'(ctl_off), 32'(m_off));
      for (int c = 0; c < 4; c++) begin
         chk({tag, " addr R3"}, 32'(ch_addr[c*16 +: 16]), 32'(m_cur[c]));
         chk({tag, " done R11"}, 32'(ch_done[c*16 +: 16]), 32'(m_done[c]));
         chk({tag, " len R2"}, 32'(ch_len[c*16 +: 16]), 32'(m_bc[c]));
         chk({tag, " mode R7"}, 32'(ch_mode[c*8 +: 8]), 32'(m_mode[c]));
      end
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int unused_seed;
      unused_seed = $urandom(32'd1234);
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 rdata", 32'(bus_rdata), 32'h0);
      check_outs("R1");
      mrd(4'd15, "R1 mask read R9");
      mrd(4'd8, "R1 status read R9");

      // R2: address of channel 1, low then high, readback
      mwr(4'd2, 8'h34); mwr(4'd2, 8'h12);
      chk("R2 R3 ch1 addr", 32'(ch_addr[16 +: 16]), 32'h1234);
      mrd(4'd2, "R2 lo"); mrd(4'd2, "R2 hi");
      // R11 then R3 reload clears transferred count
      pulse(4'b0010, 4'b0000); pulse(4'b0010, 4'b0000); pulse(4'b0010, 4'b0000);
      chk("R11 done", 32'(ch_done[16 +: 16]), 32'd3);
      mrd(4'd2, "R10 addr lo up"); mrd(4'd2, "R10 addr hi up");
      mwr(4'd3, 8'h00); mwr(4'd3, 8'h01);
      chk("R3 done cleared", 32'(ch_done[16 +: 16]), 32'd0);

      // R7 R10 decrement and count readback on channel 2
      mwr(4'd11, 8'h22);
      mwr(4'd4, 8'h00); mwr(4'd4, 8'h01);
      mwr(4'd5, 8'h10); mwr(4'd5, 8'h00);
      pulse(4'b0100, 4'b0000); pulse(4'b0100, 4'b0000);
      mrd(4'd4, "R10 dec lo"); mrd(4'd4, "R10 dec hi");
      mrd(4'd5, "R10 cnt lo"); mrd(4'd5, "R10 cnt hi");
      check_outs("R7");

      // R4 command accept and reject
      mwr(4'd8, 8'h04); chk("R4 accept", 32'(ctl_off), 32'd1);
      mwr(4'd8, 8'h05); chk("R4 reject", 32'(ctl_off), 32'd1);
      mwr(4'd8, 8'h84); chk("R4 reject hi", 32'(ctl_off), 32'd1);
      mwr(4'd8, 8'h00); chk("R4 zero", 32'(ctl_off), 32'd0);

      // R5 R9 R11 status
      pulse(4'b0000, 4'b1001);
      mwr(4'd9, 8'h07);
      mrd(4'd8, "R5 R9 status first");
      mrd(4'd8, "R9 status cleared");
      mrd(4'd10, "R9 other reads zero");

      // R6 mask ops
      mwr(4'd14, 8'h00); mwr(4'd10, 8'h06); mrd(4'd15, "R6 single");
      mwr(4'd15, 8'hFA); mrd(4'd15, "R6 all");

      // R8 pointer clear, then master reset
      mwr(4'd0, 8'hAA); mwr(4'd12, 8'h00); mwr(4'd0, 8'h55);
      mrd(4'd0, "R8 ptr cleared");
      mwr(4'd8, 8'h04); pulse(4'b0000, 4'b0100); mwr(4'd13, 8'h00);
      check_outs("R8 master");
      mrd(4'd8, "R8 status after master");

      // R12 write wins over simultaneous read
      mrd(4'd15, "R12 prime");
      @(negedge clk);
      bus_wr = 1'b1; bus_rd = 1'b1; bus_idx = 4'd14; bus_wdata = 8'h00;
      @(negedge clk);
      bus_wr = 1'b0; bus_rd = 1'b0;
      m_mask = 0;
      chk("R12 rdata held", 32'(bus_rdata), 32'h0F);
      check_outs("R12");

      // constrained random mix
      for (int i = 0; i < 600; i++) begin
         int k;
         logic [3:0] ix;
         k  = $urandom_range(0, 9);
         ix = 4'($urandom_range(0, 15));
         if (k < 4) mwr(ix, 8'($urandom));
         else if (k < 8) mrd(ix, "R10 R9 random read");
         else pulse(4'($urandom), (k == 9) ? 4'($urandom) : 4'h0);
         if (i % 8 == 0) check_outs("R2 random");
      end
      check_outs("final");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule